// File: doc/BRIEF.md
# External memory interface controller

This block sits between a simple CPU data-memory port and two kinds of storage: a small on-chip RAM and an external memory bus. A configuration register picks one of four steering modes. Every access can stay on-chip, or every access can go off-chip. In the two split modes, the effective address is compared against a fixed 4 kB boundary. Accesses come in two forms. A wide access carries a full 16-bit address. A narrow access carries only the low byte, and the block supplies the upper byte.

For a narrow access, the upper byte comes from one of two places. In the split mode without banking, it is taken from the current value of an address-high port latch input. In every other mode, it is taken from a page register held inside the block.

The external bus has two forms. In the multiplexed form, the low address byte shares the data lines and an address-latch-enable strobe marks it. Its high time and its low time are each programmable from 1 to 4 clocks. In the separate form, the address uses its own pins and no latch-enable pulse is produced. A busy flag covers the whole external cycle, and a one-clock ready pulse closes every access. The CPU waits for ready and does not issue a new request while busy.

Top module: `xmem_ctrl`

## Requirements
- R1: After reset the configuration register reads 0x03 and the page register reads 0x00. Configuration bits [7:5] always read zero and ignore writes. Writing 0xFF reads back 0x1F.
- R2: The mode field is configuration bits [3:2]. In mode 00 every access goes to the on-chip RAM. The RAM index is the effective address modulo the RAM depth (256 bytes by default), so an address of any value aliases into the RAM.
- R3: In mode 01, an effective address below 0x1000 goes on-chip and one at or above 0x1000 goes off-chip. A narrow access (`cpu_wide`=0) takes its upper byte from `port_hi`.
- R4: In mode 10 the same 0x1000 boundary applies. A narrow access takes its upper byte from the page register.
- R5: In mode 11 every access goes off-chip, including addresses below 0x1000.
- R6: A wide access (`cpu_wide`=1) uses `cpu_addr` unchanged as its effective address in every mode. Neither the page register nor `port_hi` affects it.
- R7: Configuration bit 4 selects the bus form, with 0 meaning multiplexed. The width code is bits [1:0] and gives W = code+1. In the multiplexed form, `xale` is high for W clocks and then low for W clocks. Throughout both phases, `xd_out` carries the low address byte with `xd_oe`=1. One strobe clock follows. `xa_hi` carries the upper byte for the whole cycle.
- R8: When bit 4 is 1 (separate form), `xale` stays low. `xa_lo` carries the low byte and the strobe is asserted in the first clock after acceptance, whatever the width code.
- R9: In a write strobe clock, `xwr_n`=0, `xd_out` equals the write data and `xd_oe`=1. In a read strobe clock, `xrd_n`=0 and `xd_oe`=0. The value on `xd_in` in that clock is returned on `cpu_rdata` with the ready pulse.
- R10: `cpu_busy` is high from the clock after acceptance until the ready pulse. That is 2W+1 clocks in the multiplexed form and 1 clock in the separate form. In the clock of `cpu_rdy`, `cpu_busy` is low and both strobes are high.
- R11: An on-chip access never raises `cpu_busy`. It gives `cpu_rdy` in the next clock and leaves `xrd_n`, `xwr_n` high and `xale` low. A read returns the byte last written at that RAM index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | One-clock access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_wide | input | 1 | 1 = 16-bit address form, 0 = 8-bit form |
| cpu_addr | input | 16 | Access address (low byte only for 8-bit form) |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid with cpu_rdy |
| cpu_busy | output | 1 | External cycle in progress |
| cpu_rdy | output | 1 | One-clock completion pulse |
| port_hi | input | 8 | Address-high port latch value |
| cfg_we | input | 1 | Configuration register write |
| cfg_wdata | input | 8 | Configuration write value |
| cfg_rdata | output | 8 | Configuration register value |
| pg_we | input | 1 | Page register write |
| pg_wdata | input | 8 | Page write value |
| pg_rdata | output | 8 | Page register value |
| xa_hi | output | 8 | External upper address pins |
| xa_lo | output | 8 | External low address pins (separate form) |
| xd_out | output | 8 | External data/address lines out |
| xd_oe | output | 1 | Drive enable for external data lines |
| xd_in | input | 8 | External data lines in |
| xale | output | 1 | Address latch enable |
| xrd_n | output | 1 | External read strobe, active low |
| xwr_n | output | 1 | External write strobe, active low |

## Verification
Some properties are checked on every cycle:
- the read and write strobes are never asserted together;
- the data lines are released during a read strobe;
- latch-enable only occurs while the address is being driven;
- a latch-enable fall is never followed directly by a strobe;
- ready never coincides with busy;
- on-chip accesses leave the external strobes quiet;
- the registers come out of reset with their defined values.

Other behaviour can only be shown by the bench's scenarios:
- the exact steering decision for each mode at the 0x0FFF/0x1000 boundary;
- where the upper byte of a narrow access comes from;
- aliasing of on-chip addresses;
- the exact latch-enable phase lengths for every width code;
- write data on the lines, and read data returned to the CPU.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

  localparam logic [1:0] MODE_INT   = 2'b00;
  localparam logic [1:0] MODE_SPLIT = 2'b01;
  localparam logic [1:0] MODE_BANK  = 2'b10;
  localparam logic [1:0] MODE_EXT   = 2'b11;

  typedef struct packed {
    logic       sep;       // 1 = separate address/data pins
    logic [1:0] mode;      // steering mode
    logic [1:0] ale_code;  // latch-enable width code
  } xcfg_t;

  typedef enum logic [1:0] {
    BS_IDLE = 2'd0,
    BS_AHI  = 2'd1,
    BS_ALO  = 2'd2,
    BS_STB  = 2'd3
  } bus_st_t;

endpackage

// File: rtl/xmem_regs.sv
module xmem_regs
  import xmem_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              pg_we,
  input  logic [DATA_W-1:0] pg_wdata,
  output xcfg_t             cfg,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic [DATA_W-1:0] pg_rdata
);

  localparam int CFG_W = $bits(xcfg_t);

  xcfg_t             cfg_q;
  logic [DATA_W-1:0] pg_q;
  logic              unused_cfg_hi;

  assign unused_cfg_hi = ^cfg_wdata[DATA_W-1:CFG_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '{sep: 1'b0, mode: MODE_INT, ale_code: 2'b11};
      pg_q  <= '0;
    end else begin
      if (cfg_we) cfg_q <= xcfg_t'(cfg_wdata[CFG_W-1:0]);
      if (pg_we)  pg_q  <= pg_wdata;
    end
  end

  assign cfg       = cfg_q;
  assign cfg_rdata = {{(DATA_W-CFG_W){1'b0}}, cfg_q};
  assign pg_rdata  = pg_q;

  // R1: register values right after reset
  a_r1_reset_values: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cfg_rdata == DATA_W'(8'h03) && pg_rdata == '0));

endmodule

// File: rtl/xmem_steer.sv
module xmem_steer
  import xmem_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int SPLIT_BOUND = 4096
) (
  input  logic [1:0]        mode,
  input  logic              wide,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] page,
  input  logic [DATA_W-1:0] port_hi,
  output logic [ADDR_W-1:0] eff,
  output logic              onchip
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic [HI_W-1:0] upper;

  always_comb begin
    if (wide)                    upper = addr[ADDR_W-1:DATA_W];
    else if (mode == MODE_SPLIT) upper = HI_W'(port_hi);
    else                         upper = HI_W'(page);
    eff = {upper, addr[DATA_W-1:0]};
    unique case (mode)
      MODE_INT:   onchip = 1'b1;
      MODE_SPLIT,
      MODE_BANK:  onchip = (eff < ADDR_W'(SPLIT_BOUND));
      default:    onchip = 1'b0;
    endcase
  end

endmodule

// File: rtl/xmem_sram.sv
module xmem_sram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] a,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] q
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[a] <= wd;
      q <= mem[a];
    end
  end

endmodule

// File: rtl/xmem_bus.sv
module xmem_bus
  import xmem_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              sep,
  input  logic [1:0]        code,
  input  logic              we,
  input  logic [ADDR_W-1:0] eff,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] xd_in,
  output logic              busy,
  output logic              rdy,
  output logic [DATA_W-1:0] rq,
  output logic [ADDR_W-DATA_W-1:0] xa_hi,
  output logic [DATA_W-1:0] xa_lo,
  output logic [DATA_W-1:0] xd_out,
  output logic              xd_oe,
  output logic              xale,
  output logic              xrd_n,
  output logic              xwr_n
);

  bus_st_t           st;
  logic [1:0]        cnt;
  logic [1:0]        code_q;
  logic              we_q;
  logic [DATA_W-1:0] wd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= BS_IDLE;
      cnt    <= '0;
      code_q <= '0;
      we_q   <= 1'b0;
      wd_q   <= '0;
      busy   <= 1'b0;
      rdy    <= 1'b0;
      rq     <= '0;
      xa_hi  <= '0;
      xa_lo  <= '0;
      xd_out <= '0;
      xd_oe  <= 1'b0;
      xale   <= 1'b0;
      xrd_n  <= 1'b1;
      xwr_n  <= 1'b1;
    end else begin
      rdy <= 1'b0;
      unique case (st)
        BS_IDLE: begin
          if (start) begin
            busy   <= 1'b1;
            xa_hi  <= eff[ADDR_W-1:DATA_W];
            code_q <= code;
            we_q   <= we;
            wd_q   <= wdata;
            if (!sep) begin
              st     <= BS_AHI;
              cnt    <= code;
              xale   <= 1'b1;
              xa_lo  <= '0;
              xd_out <= eff[DATA_W-1:0];
              xd_oe  <= 1'b1;
            end else begin
              st    <= BS_STB;
              xa_lo <= eff[DATA_W-1:0];
              if (we) begin
                xwr_n  <= 1'b0;
                xd_out <= wdata;
                xd_oe  <= 1'b1;
              end else begin
                xrd_n <= 1'b0;
                xd_oe <= 1'b0;
              end
            end
          end
        end
        BS_AHI: begin
          if (cnt == 2'd0) begin
            xale <= 1'b0;
            cnt  <= code_q;
            st   <= BS_ALO;
          end else begin
            cnt <= cnt - 2'd1;
          end
        end
        BS_ALO: begin
          if (cnt == 2'd0) begin
            st <= BS_STB;
            if (we_q) begin
              xwr_n  <= 1'b0;
              xd_out <= wd_q;
              xd_oe  <= 1'b1;
            end else begin
              xrd_n <= 1'b0;
              xd_oe <= 1'b0;
            end
          end else begin
            cnt <= cnt - 2'd1;
          end
        end
        default: begin
          if (!we_q) rq <= xd_in;
          xrd_n <= 1'b1;
          xwr_n <= 1'b1;
          xd_oe <= 1'b0;
          busy  <= 1'b0;
          rdy   <= 1'b1;
          st    <= BS_IDLE;
        end
      endcase
    end
  end

  // R9: strobes are mutually exclusive
  a_r9_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(!xrd_n && !xwr_n));

  // R9: data lines released while reading
  a_r9_read_float: assert property (@(posedge clk) disable iff (rst)
    !xrd_n |-> !xd_oe);

  // R7: latch-enable only while the address is on the lines
  a_r7_ale_drives: assert property (@(posedge clk) disable iff (rst)
    xale |-> (xd_oe && xrd_n && xwr_n && busy));

  // R7: latch-enable falls at least one clock before the strobe
  a_r7_low_phase: assert property (@(posedge clk) disable iff (rst)
    $fell(xale) |-> (xrd_n && xwr_n));

  // R8: separate-form cycle never raises latch-enable
  a_r8_no_ale_sep: assert property (@(posedge clk) disable iff (rst)
    (st == BS_IDLE && start && sep) |=> !xale);

endmodule

// File: rtl/xmem_ctrl.sv
module xmem_ctrl
  import xmem_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int RAM_AW      = 8,
  parameter int SPLIT_BOUND = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic              cpu_wide,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_busy,
  output logic              cpu_rdy,
  input  logic [DATA_W-1:0] port_hi,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              pg_we,
  input  logic [DATA_W-1:0] pg_wdata,
  output logic [DATA_W-1:0] pg_rdata,
  output logic [ADDR_W-DATA_W-1:0] xa_hi,
  output logic [DATA_W-1:0] xa_lo,
  output logic [DATA_W-1:0] xd_out,
  output logic              xd_oe,
  input  logic [DATA_W-1:0] xd_in,
  output logic              xale,
  output logic              xrd_n,
  output logic              xwr_n
);

  xcfg_t             cfg;
  logic [ADDR_W-1:0] eff;
  logic              onchip;
  logic              accept;
  logic              ram_en;
  logic              ext_start;
  logic [DATA_W-1:0] ram_q;
  logic [DATA_W-1:0] bus_rq;
  logic              bus_busy;
  logic              bus_rdy;
  logic              ram_rdy;
  logic              src_ram;

  xmem_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .pg_we(pg_we), .pg_wdata(pg_wdata),
    .cfg(cfg), .cfg_rdata(cfg_rdata), .pg_rdata(pg_rdata)
  );

  xmem_steer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SPLIT_BOUND(SPLIT_BOUND)) u_steer (
    .mode(cfg.mode), .wide(cpu_wide), .addr(cpu_addr),
    .page(pg_rdata), .port_hi(port_hi),
    .eff(eff), .onchip(onchip)
  );

  assign accept    = cpu_req && !bus_busy;
  assign ram_en    = accept && onchip;
  assign ext_start = accept && !onchip;

  xmem_sram #(.AW(RAM_AW), .DW(DATA_W)) u_ram (
    .clk(clk), .en(ram_en), .we(cpu_we),
    .a(eff[RAM_AW-1:0]), .wd(cpu_wdata), .q(ram_q)
  );

  xmem_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk(clk), .rst(rst), .start(ext_start),
    .sep(cfg.sep), .code(cfg.ale_code), .we(cpu_we),
    .eff(eff), .wdata(cpu_wdata), .xd_in(xd_in),
    .busy(bus_busy), .rdy(bus_rdy), .rq(bus_rq),
    .xa_hi(xa_hi), .xa_lo(xa_lo), .xd_out(xd_out), .xd_oe(xd_oe),
    .xale(xale), .xrd_n(xrd_n), .xwr_n(xwr_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_rdy <= 1'b0;
      src_ram <= 1'b0;
    end else begin
      ram_rdy <= ram_en;
      if (ram_en)         src_ram <= 1'b1;
      else if (ext_start) src_ram <= 1'b0;
    end
  end

  assign cpu_busy  = bus_busy;
  assign cpu_rdy   = ram_rdy | bus_rdy;
  assign cpu_rdata = src_ram ? ram_q : bus_rq;

  // R11: on-chip access leaves the external bus quiet
  a_r11_onchip_quiet: assert property (@(posedge clk) disable iff (rst)
    ram_en |=> (xrd_n && xwr_n && !xale && !cpu_busy));

  // R10: ready never overlaps busy
  a_r10_rdy_not_busy: assert property (@(posedge clk) disable iff (rst)
    cpu_rdy |-> (!cpu_busy && xrd_n && xwr_n));

  // R5: mode 11 never reaches the RAM
  a_r5_ext_only: assert property (@(posedge clk) disable iff (rst)
    (accept && cfg.mode == MODE_EXT) |=> cpu_busy);

endmodule

// File: tb/sim_xmem_ctrl.sv
module sim_xmem_ctrl;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 0, cpu_we = 0, cpu_wide = 0;
  logic [15:0] cpu_addr = 0;
  logic [7:0]  cpu_wdata = 0;
  logic [7:0]  cpu_rdata;
  logic        cpu_busy, cpu_rdy;
  logic [7:0]  port_hi = 0;
  logic        cfg_we = 0, pg_we = 0;
  logic [7:0]  cfg_wdata = 0, pg_wdata = 0;
  logic [7:0]  cfg_rdata, pg_rdata;
  logic [7:0]  xa_hi, xa_lo, xd_out;
  logic        xd_oe, xale, xrd_n, xwr_n;
  logic [7:0]  xd_in = 0;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [7:0] shadow [256];
  bit         valid  [256];
  logic [7:0] cfg_m = 8'h03;
  logic [7:0] pg_m = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  xmem_ctrl u0 (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_wide(cpu_wide),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_busy(cpu_busy), .cpu_rdy(cpu_rdy), .port_hi(port_hi),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .pg_we(pg_we), .pg_wdata(pg_wdata), .pg_rdata(pg_rdata),
    .xa_hi(xa_hi), .xa_lo(xa_lo), .xd_out(xd_out), .xd_oe(xd_oe), .xd_in(xd_in),
    .xale(xale), .xrd_n(xrd_n), .xwr_n(xwr_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [7:0] v);
    @(negedge clk); cfg_we = 1; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
    cfg_m = {3'b000, v[4:0]};
  endtask

  task automatic set_pg(input logic [7:0] v);
    @(negedge clk); pg_we = 1; pg_wdata = v;
    @(negedge clk); pg_we = 0;
    pg_m = v;
  endtask

  // One access; expected behaviour derived from the requirements.
  task automatic access(input bit we, input bit wide, input logic [15:0] a,
                        input logic [7:0] wd, input string tag);
    logic [15:0] e;
    logic [1:0]  md;
    bit          onc, sep;
    int          w;
    logic [7:0]  rd_exp;
    md  = cfg_m[3:2];
    sep = cfg_m[4];
    w   = int'(cfg_m[1:0]) + 1;
    e[7:0]  = a[7:0];
    e[15:8] = wide ? a[15:8] : (md == 2'b01 ? port_hi : pg_m);
    onc = (md == 2'b00) || ((md == 2'b01 || md == 2'b10) && e < 16'h1000);
    rd_exp = e[7:0] ^ e[15:8] ^ 8'h3C;
    xd_in = rd_exp;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_wide = wide; cpu_addr = a; cpu_wdata = wd;
    @(negedge clk);
    cpu_req = 0;
    if (onc) begin
      chk(cpu_rdy && !cpu_busy && xrd_n && xwr_n && !xale, {tag, " R11 onchip quiet"},
          {cpu_rdy, cpu_busy, xrd_n, xwr_n, xale}, 5'b10110);
      if (we) begin
        shadow[e[7:0]] = wd; valid[e[7:0]] = 1;
      end else if (valid[e[7:0]]) begin
        chk(cpu_rdata == shadow[e[7:0]], {tag, " R2 R11 onchip data"},
            cpu_rdata, shadow[e[7:0]]);
      end
    end else begin
      if (!sep) begin
        for (int k = 0; k < 2*w; k++) begin
          chk(xale == (k < w) && xd_oe && xd_out == e[7:0] && xa_hi == e[15:8]
              && cpu_busy && xrd_n && xwr_n && !cpu_rdy,
              {tag, " R7 R10 address phase"}, {xale, xd_oe, xd_out, xa_hi},
              {(k < w) ? 1'b1 : 1'b0, 1'b1, e[7:0], e[15:8]});
          @(negedge clk);
        end
      end else begin
        chk(!xale && xa_lo == e[7:0], {tag, " R8 separate address"},
            {xale, xa_lo}, {1'b0, e[7:0]});
      end
      if (we)
        chk(!xwr_n && xrd_n && xd_oe && xd_out == wd && xa_hi == e[15:8] && cpu_busy && !xale,
            {tag, " R9 write strobe"}, {xwr_n, xrd_n, xd_oe, xd_out, xa_hi},
            {1'b0, 1'b1, 1'b1, wd, e[15:8]});
      else
        chk(!xrd_n && xwr_n && !xd_oe && xa_hi == e[15:8] && cpu_busy && !xale,
            {tag, " R9 read strobe"}, {xrd_n, xwr_n, xd_oe, xa_hi},
            {1'b0, 1'b1, 1'b0, e[15:8]});
      @(negedge clk);
      chk(cpu_rdy && !cpu_busy && xrd_n && xwr_n, {tag, " R10 completion"},
          {cpu_rdy, cpu_busy, xrd_n, xwr_n}, 4'b1011);
      if (!we)
        chk(cpu_rdata == rd_exp, {tag, " R9 read data"}, cpu_rdata, rd_exp);
    end
    @(negedge clk);
    chk(!cpu_rdy && !cpu_busy, {tag, " R10 idle after"}, {cpu_rdy, cpu_busy}, 0);
  endtask

  // Check whether an access goes on-chip: the busy flag is the port-visible answer.
  task automatic route(input bit wide, input logic [15:0] a, input bit exp_ext, input string tag);
    @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_wide = wide; cpu_addr = a;
    @(negedge clk);
    cpu_req = 0;
    chk(cpu_busy == exp_ext, tag, cpu_busy, exp_ext);
    while (!cpu_rdy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(cfg_rdata == 8'h03, "R1 cfg reset", cfg_rdata, 8'h03);
    chk(pg_rdata == 8'h00, "R1 page reset", pg_rdata, 0);
    chk(!cpu_busy && !cpu_rdy && xrd_n && xwr_n && !xale && !xd_oe, "R1 idle outputs",
        {cpu_busy, cpu_rdy, xrd_n, xwr_n, xale, xd_oe}, 6'b001100);
    set_cfg(8'hFF);
    chk(cfg_rdata == 8'h1F, "R1 top bits ignored", cfg_rdata, 8'h1F);

    // Mode 00: everything on-chip with aliasing
    set_cfg(8'h00);
    set_pg(8'h9A);
    access(1, 1, 16'h0012, 8'hC3, "m00");
    access(0, 1, 16'h5112, 8'h00, "m00 R2 alias");
    access(1, 1, 16'hFFFF, 8'h71, "m00");
    access(0, 0, 16'h00FF, 8'h00, "m00 R2 narrow");
    route(1, 16'hF000, 0, "R2 high addr onchip");

    // Mode 11 multiplexed, sweep width codes
    for (int c = 0; c < 4; c++) begin
      set_cfg(8'h0C | 8'(c));
      access(0, 1, 16'h0034 + 16'(c), 8'h00, "m11 R5 low addr");
      access(1, 1, 16'hBE00 + 16'(c), 8'hA0 + 8'(c), "m11 write");
      access(0, 0, 16'h0066, 8'h00, "m11 narrow page");
    end

    // Mode 01: port latch supplies upper byte
    set_pg(8'h77);
    for (int c = 0; c < 4; c += 3) begin
      set_cfg(8'h04 | 8'(c));
      port_hi = 8'h23;
      access(0, 0, 16'hEE45, 8'h00, "m01 R3 latch ext");
      route(0, 16'h0045, 1, "R3 latch 0x23 ext");
      port_hi = 8'h0F;
      route(0, 16'h0045, 0, "R3 latch 0x0F onchip");
      access(1, 0, 16'h0045, 8'h5D, "m01 R3 onchip");
      route(1, 16'h0FFF, 0, "R3 boundary 0x0FFF");
      route(1, 16'h1000, 1, "R3 boundary 0x1000");
      access(0, 1, 16'hABCD, 8'h00, "m01 R6 wide");
      port_hi = 8'h00;
      access(0, 1, 16'h0F45, 8'h00, "m01 R6 wide onchip");
    end

    // Mode 10: page register supplies upper byte
    set_cfg(8'h09);
    port_hi = 8'h01;
    set_pg(8'h81);
    access(1, 0, 16'h0010, 8'h3E, "m10 R4 page ext");
    route(0, 16'h0010, 1, "R4 page 0x81 ext");
    set_pg(8'h05);
    route(0, 16'h0010, 0, "R4 page 0x05 onchip");
    access(1, 0, 16'h0010, 8'h4B, "m10 R4 onchip");
    access(0, 0, 16'h0010, 8'h00, "m10 R4 onchip read");
    route(1, 16'h1000, 1, "R4 boundary 0x1000");
    access(0, 1, 16'h2222, 8'h00, "m10 R6 wide");

    // Separate form: width code has no effect
    for (int c = 0; c < 4; c++) begin
      set_cfg(8'h1C | 8'(c));
      access(0, 1, 16'h1357 + 16'(c), 8'h00, "sep R8 read");
      access(1, 1, 16'h0246, 8'h90 + 8'(c), "sep R8 write");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule